// File: doc/BRIEF.md
# Out-of-Order Function Unit Scoreboard

This block controls issue, operand reads and result writeback for a group of non-pipelined function units that share one register file. Instructions arrive in program order at a single issue port, each naming a target unit, a destination register and up to two source registers. The scoreboard keeps one status entry per unit and one reservation entry per register. It issues an instruction as soon as its unit is free and no other unit holds its destination. It tells a unit to fetch operands once every source has been produced. It picks at most one unit per cycle to use the single write port, and holds a result back while an older reader still needs the previous value of that register. Units therefore read operands and complete in any order.

Each unit slot runs a four-state machine. S_IDLE moves to S_WAIT_OPS on an accepted issue. S_WAIT_OPS moves to S_EXEC on a read grant. S_EXEC moves to S_DONE when the unit raises its completion request. S_DONE moves back to S_IDLE on the writeback grant. The arithmetic and the register data path sit outside this block. The execution latency of each unit is whatever time passes between its read grant and its completion request.

Top module: `scoreboard_ctrl`

## Requirements
- R1: `iss_ready` is low while the unit selected by `iss_fu` is in any state other than S_IDLE, and a request presented while it is low changes no state.
- R2: `iss_ready` is low while the register on `iss_dst` is reserved by a pending result (WAW). The reservation is dropped at the end of the writeback cycle of the reserving unit, so the stalled issue is accepted in the following cycle.
- R3: A unit whose used sources have no pending producer at issue gets `rd_grant` in the cycle after issue. A source whose producer writes back in the issue cycle itself counts as available. Any other pending source holds `rd_grant` off until the cycle after that producer's writeback grant.
- R4: Two register read ports are shared. Units are scanned from index 0 upward, and a ready unit is granted when its operand count (use1 + use2) still fits in the remaining ports. Per cycle, the sum of granted operand counts never exceeds 2.
- R5: `rd_grant` moves a unit to S_EXEC. A `done_req` in S_EXEC moves it to S_DONE. A `done_req` in any other state is ignored.
- R6: `wb_grant` is zero or one-hot, and it goes to the lowest-index unit that is in S_DONE and free of WAR conflicts. A unit whose `done_req` is seen in cycle c is granted in c+1 at the earliest. `wb_dst` and `wb_op` show that unit's destination and opcode.
- R7: A unit in S_DONE is not granted writeback while another unit is in S_WAIT_OPS with an available, used source equal to its destination. This holds in the cycle that other unit receives its read grant as well.
- R8: Completion is out of order: a later-issued unit with a short latency writes back before an earlier-issued long-latency unit.
- R9: A unit is freed in its writeback cycle. `iss_ready` for it stays low during that cycle and is high (destination permitting) in the next.
- R10: After reset all units are in S_IDLE, no register is reserved, `iss_ready` is high, and `rd_grant` and `wb_grant` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iss_valid | input | 1 | Issue request present |
| iss_fu | input | FU_W | Target function unit index |
| iss_op | input | OP_W | Opcode recorded for the unit |
| iss_dst | input | REG_W | Destination register |
| iss_src1 | input | REG_W | First source register |
| iss_src2 | input | REG_W | Second source register |
| iss_use1 | input | 1 | First source is used |
| iss_use2 | input | 1 | Second source is used |
| iss_ready | output | 1 | Request would be accepted at this edge |
| rd_grant | output | NUM_FU | Per-unit operand fetch permission |
| done_req | input | NUM_FU | Per-unit completion request |
| wb_grant | output | NUM_FU | Per-unit write port grant, at most one bit |
| wb_dst | output | REG_W | Destination of the writing unit |
| wb_op | output | OP_W | Opcode of the writing unit |

## Verification
The embedded properties check, on every cycle, the invariants that do not depend on history: writeback grants are one-hot, go only to finished units and never break a pending read of an old value; read grants go only to ready units and never oversubscribe the ports; an issue reserves its destination and a writeback releases it. Only the directed scenarios can show the timing. These are the exact cycle distances from issue to read and to writeback, the wakeup of a consumer one cycle after its producer's writeback, the point at which a WAW stall lifts, the port split when three readers wake together, and the order of completion when short operations overtake long ones.

// File: rtl/sb_pkg.sv
`timescale 1ns/1ps
package sb_pkg;
    typedef enum logic [1:0] {
        S_IDLE     = 2'd0,
        S_WAIT_OPS = 2'd1,
        S_EXEC     = 2'd2,
        S_DONE     = 2'd3
    } slot_state_e;
endpackage

// File: rtl/sb_issue_check.sv
`timescale 1ns/1ps
module sb_issue_check #(
    parameter int NUM_FU  = 4,
    parameter int NUM_REG = 8,
    parameter int REG_W   = 3,
    parameter int FU_W    = 2
) (
    input  logic                           iss_valid,
    input  logic [FU_W-1:0]                iss_fu,
    input  logic [REG_W-1:0]               iss_dst,
    input  logic [REG_W-1:0]               iss_src1,
    input  logic [REG_W-1:0]               iss_src2,
    input  logic                           iss_use1,
    input  logic                           iss_use2,
    input  logic [NUM_FU-1:0]              busy_vec,
    input  logic [NUM_REG-1:0]             res_valid,
    input  logic [NUM_REG-1:0][FU_W-1:0]   res_fu,
    input  logic [NUM_FU-1:0]              wb_grant,
    output logic                           iss_ready,
    output logic [NUM_FU-1:0]              fire_vec,
    output logic                           pend1,
    output logic                           pend2,
    output logic [FU_W-1:0]                prod1,
    output logic [FU_W-1:0]                prod2
);
    // structural hazard on the unit, WAW hazard on the destination
    assign iss_ready = !busy_vec[iss_fu] && !res_valid[iss_dst];

    // producer lookup; a producer writing back this cycle counts as done
    assign prod1 = res_fu[iss_src1];
    assign prod2 = res_fu[iss_src2];
    assign pend1 = iss_use1 && res_valid[iss_src1] && !wb_grant[prod1];
    assign pend2 = iss_use2 && res_valid[iss_src2] && !wb_grant[prod2];

    for (genvar i = 0; i < NUM_FU; i++) begin : g_fire
        assign fire_vec[i] = iss_valid && iss_ready && (iss_fu == FU_W'(i));
    end
endmodule

// File: rtl/sb_fu_slot.sv
`timescale 1ns/1ps
module sb_fu_slot
    import sb_pkg::*;
#(
    parameter int NUM_FU = 4,
    parameter int REG_W  = 3,
    parameter int OP_W   = 4,
    parameter int FU_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [OP_W-1:0]   op_in,
    input  logic [REG_W-1:0]  dst_in,
    input  logic [REG_W-1:0]  src1_in,
    input  logic [REG_W-1:0]  src2_in,
    input  logic              use1_in,
    input  logic              use2_in,
    input  logic              pend1_in,
    input  logic              pend2_in,
    input  logic [FU_W-1:0]   prod1_in,
    input  logic [FU_W-1:0]   prod2_in,
    input  logic              rd_grant,
    input  logic              done_req,
    input  logic              wb_grant,
    input  logic [NUM_FU-1:0] wb_vec,
    output logic              busy,
    output logic              rd_cand,
    output logic [1:0]        rd_need,
    output logic              done,
    output logic              war1,
    output logic              war2,
    output logic [REG_W-1:0]  dst_o,
    output logic [REG_W-1:0]  src1_o,
    output logic [REG_W-1:0]  src2_o,
    output logic [OP_W-1:0]   op_o
);
    slot_state_e state_q, state_d;

    logic [OP_W-1:0]  op_q;
    logic [REG_W-1:0] dst_q, src1_q, src2_q;
    logic             use1_q, use2_q, rdy1_q, rdy2_q;
    logic [FU_W-1:0]  prod1_q, prod2_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:     if (issue)    state_d = S_WAIT_OPS;
            S_WAIT_OPS: if (rd_grant) state_d = S_EXEC;
            S_EXEC:     if (done_req) state_d = S_DONE;
            S_DONE:     if (wb_grant) state_d = S_IDLE;
        endcase
    end

    // status entry: fields latched at issue, source flags woken by writebacks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= '0;
            dst_q   <= '0;
            src1_q  <= '0;
            src2_q  <= '0;
            use1_q  <= 1'b0;
            use2_q  <= 1'b0;
            rdy1_q  <= 1'b0;
            rdy2_q  <= 1'b0;
            prod1_q <= '0;
            prod2_q <= '0;
        end else if (issue && state_q == S_IDLE) begin
            op_q    <= op_in;
            dst_q   <= dst_in;
            src1_q  <= src1_in;
            src2_q  <= src2_in;
            use1_q  <= use1_in;
            use2_q  <= use2_in;
            rdy1_q  <= !pend1_in;
            rdy2_q  <= !pend2_in;
            prod1_q <= prod1_in;
            prod2_q <= prod2_in;
        end else if (state_q == S_WAIT_OPS) begin
            if (!rdy1_q && wb_vec[prod1_q]) rdy1_q <= 1'b1;
            if (!rdy2_q && wb_vec[prod2_q]) rdy2_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy    = (state_q != S_IDLE);
        rd_cand = (state_q == S_WAIT_OPS) && rdy1_q && rdy2_q;
        rd_need = {1'b0, use1_q} + {1'b0, use2_q};
        done    = (state_q == S_DONE);
        war1    = (state_q == S_WAIT_OPS) && use1_q && rdy1_q;
        war2    = (state_q == S_WAIT_OPS) && use2_q && rdy2_q;
        dst_o   = dst_q;
        src1_o  = src1_q;
        src2_o  = src2_q;
        op_o    = op_q;
    end

    // R3
    grant_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |-> rd_cand);
    // R5
    grant_enters_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_grant |=> (state_q == S_EXEC));
    // R5
    stray_done_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && done_req && !issue) |=> !done && !busy);
    // R9
    freed_after_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_grant |=> !busy);
endmodule

// File: rtl/sb_read_arbiter.sv
`timescale 1ns/1ps
module sb_read_arbiter #(
    parameter int NUM_FU       = 4,
    parameter int NUM_RD_PORTS = 2,
    localparam int CW          = $clog2(NUM_RD_PORTS + 3)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_FU-1:0]      cand,
    input  logic [NUM_FU-1:0][1:0] need,
    output logic [NUM_FU-1:0]      grant
);
    logic [CW-1:0] left;
    logic [CW-1:0] used;

    // first fit from unit 0 upward
    always_comb begin
        left  = CW'(NUM_RD_PORTS);
        grant = '0;
        for (int i = 0; i < NUM_FU; i++) begin
            if (cand[i] && (CW'(need[i]) <= left)) begin
                grant[i] = 1'b1;
                left     = left - CW'(need[i]);
            end
        end
    end

    always_comb begin
        used = '0;
        for (int i = 0; i < NUM_FU; i++) begin
            if (grant[i]) used = used + CW'(need[i]);
        end
    end

    // R4
    port_budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
        used <= CW'(NUM_RD_PORTS));
    // R4
    grant_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~cand) == '0);
endmodule

// File: rtl/sb_wb_arbiter.sv
`timescale 1ns/1ps
module sb_wb_arbiter #(
    parameter int NUM_FU = 4,
    parameter int REG_W  = 3,
    parameter int FU_W   = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_FU-1:0]          done,
    input  logic [NUM_FU-1:0][REG_W-1:0] dst,
    input  logic [NUM_FU-1:0][REG_W-1:0] src1,
    input  logic [NUM_FU-1:0][REG_W-1:0] src2,
    input  logic [NUM_FU-1:0]          war1,
    input  logic [NUM_FU-1:0]          war2,
    output logic [NUM_FU-1:0]          grant,
    output logic                       any,
    output logic [FU_W-1:0]            idx
);
    logic [NUM_FU-1:0] safe;

    for (genvar f = 0; f < NUM_FU; f++) begin : g_war
        logic blk;
        always_comb begin
            blk = 1'b0;
            for (int g = 0; g < NUM_FU; g++) begin
                if (g != f) begin
                    if (war1[g] && src1[g] == dst[f]) blk = 1'b1;
                    if (war2[g] && src2[g] == dst[f]) blk = 1'b1;
                end
            end
        end
        assign safe[f] = done[f] && !blk;
    end

    always_comb begin
        grant = '0;
        any   = 1'b0;
        idx   = '0;
        for (int f = 0; f < NUM_FU; f++) begin
            if (safe[f] && !any) begin
                grant[f] = 1'b1;
                any      = 1'b1;
                idx      = FU_W'(f);
            end
        end
    end

    // R6
    wb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R6
    wb_only_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~done) == '0);

    for (genvar f = 0; f < NUM_FU; f++) begin : g_war_chk
        for (genvar g = 0; g < NUM_FU; g++) begin : g_pair
            if (g != f) begin : g_other
                // R7
                war_src1_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (grant[f] && war1[g]) |-> (src1[g] != dst[f]));
                // R7
                war_src2_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    (grant[f] && war2[g]) |-> (src2[g] != dst[f]));
            end
        end
    end
endmodule

// File: rtl/scoreboard_ctrl.sv
`timescale 1ns/1ps
module scoreboard_ctrl #(
    parameter int NUM_FU       = 4,
    parameter int NUM_REG      = 8,
    parameter int OP_W         = 4,
    parameter int NUM_RD_PORTS = 2,
    localparam int FU_W        = $clog2(NUM_FU),
    localparam int REG_W       = $clog2(NUM_REG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              iss_valid,
    input  logic [FU_W-1:0]   iss_fu,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [REG_W-1:0]  iss_dst,
    input  logic [REG_W-1:0]  iss_src1,
    input  logic [REG_W-1:0]  iss_src2,
    input  logic              iss_use1,
    input  logic              iss_use2,
    output logic              iss_ready,
    output logic [NUM_FU-1:0] rd_grant,
    input  logic [NUM_FU-1:0] done_req,
    output logic [NUM_FU-1:0] wb_grant,
    output logic [REG_W-1:0]  wb_dst,
    output logic [OP_W-1:0]   wb_op
);
    // register-result table
    logic [NUM_REG-1:0]           res_valid;
    logic [NUM_REG-1:0][FU_W-1:0] res_fu;

    logic [NUM_FU-1:0]             busy_vec, fire_vec, rd_cand, done_vec, war1_vec, war2_vec;
    logic [NUM_FU-1:0][1:0]        rd_need;
    logic [NUM_FU-1:0][REG_W-1:0]  dst_arr, src1_arr, src2_arr;
    logic [NUM_FU-1:0][OP_W-1:0]   op_arr;
    logic                          pend1, pend2, wb_any;
    logic [FU_W-1:0]               prod1, prod2, wb_idx;

    sb_issue_check #(
        .NUM_FU(NUM_FU), .NUM_REG(NUM_REG), .REG_W(REG_W), .FU_W(FU_W)
    ) issue_i (
        .iss_valid(iss_valid), .iss_fu(iss_fu), .iss_dst(iss_dst),
        .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_use1(iss_use1), .iss_use2(iss_use2),
        .busy_vec(busy_vec), .res_valid(res_valid), .res_fu(res_fu),
        .wb_grant(wb_grant), .iss_ready(iss_ready), .fire_vec(fire_vec),
        .pend1(pend1), .pend2(pend2), .prod1(prod1), .prod2(prod2)
    );

    for (genvar i = 0; i < NUM_FU; i++) begin : g_slot
        sb_fu_slot #(
            .NUM_FU(NUM_FU), .REG_W(REG_W), .OP_W(OP_W), .FU_W(FU_W)
        ) slot_i (
            .clk(clk), .rst_n(rst_n), .issue(fire_vec[i]),
            .op_in(iss_op), .dst_in(iss_dst),
            .src1_in(iss_src1), .src2_in(iss_src2),
            .use1_in(iss_use1), .use2_in(iss_use2),
            .pend1_in(pend1), .pend2_in(pend2),
            .prod1_in(prod1), .prod2_in(prod2),
            .rd_grant(rd_grant[i]), .done_req(done_req[i]),
            .wb_grant(wb_grant[i]), .wb_vec(wb_grant),
            .busy(busy_vec[i]), .rd_cand(rd_cand[i]), .rd_need(rd_need[i]),
            .done(done_vec[i]), .war1(war1_vec[i]), .war2(war2_vec[i]),
            .dst_o(dst_arr[i]), .src1_o(src1_arr[i]), .src2_o(src2_arr[i]),
            .op_o(op_arr[i])
        );
    end

    sb_read_arbiter #(
        .NUM_FU(NUM_FU), .NUM_RD_PORTS(NUM_RD_PORTS)
    ) rd_arb_i (
        .clk(clk), .rst_n(rst_n), .cand(rd_cand), .need(rd_need), .grant(rd_grant)
    );

    sb_wb_arbiter #(
        .NUM_FU(NUM_FU), .REG_W(REG_W), .FU_W(FU_W)
    ) wb_arb_i (
        .clk(clk), .rst_n(rst_n), .done(done_vec), .dst(dst_arr),
        .src1(src1_arr), .src2(src2_arr), .war1(war1_vec), .war2(war2_vec),
        .grant(wb_grant), .any(wb_any), .idx(wb_idx)
    );

    assign wb_dst = wb_any ? dst_arr[wb_idx] : '0;
    assign wb_op  = wb_any ? op_arr[wb_idx]  : '0;

    // release on writeback, reserve on issue
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= '0;
            res_fu    <= '0;
        end else begin
            if (wb_any) res_valid[wb_dst] <= 1'b0;
            if (iss_valid && iss_ready) begin
                res_valid[iss_dst] <= 1'b1;
                res_fu[iss_dst]    <= iss_fu;
            end
        end
    end

    // R1
    issue_unit_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |-> !busy_vec[iss_fu]);
    // R2
    issue_reserves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_ready) |=> res_valid[$past(iss_dst)] &&
                                     (res_fu[$past(iss_dst)] == $past(iss_fu)));
    // R6
    wb_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_any |-> res_valid[wb_dst] && (res_fu[wb_dst] == wb_idx));
    // R9
    wb_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_any |=> !res_valid[$past(wb_dst)]);
endmodule

// File: tb/scoreboard_ctrl_tb_top.sv
`timescale 1ns/1ps
module scoreboard_ctrl_tb_top;
    localparam int NF = 4;
    localparam int LAT [NF] = '{1, 2, 6, 10};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       iss_valid = 1'b0;
    logic [1:0] iss_fu = '0;
    logic [3:0] iss_op = '0;
    logic [2:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic       iss_use1 = 1'b0, iss_use2 = 1'b0;
    logic       iss_ready;
    logic [3:0] rd_grant, done_req, wb_grant, wb_op;
    logic [3:0] force_done = '0;
    logic [2:0] wb_dst;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int cnt [NF];
    int iss_cyc [NF];
    int rd_cyc [NF];
    int wb_cyc [NF];

    always #5 clk = ~clk;

    scoreboard_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_fu(iss_fu),
        .iss_op(iss_op), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_use1(iss_use1), .iss_use2(iss_use2), .iss_ready(iss_ready),
        .rd_grant(rd_grant), .done_req(done_req), .wb_grant(wb_grant),
        .wb_dst(wb_dst), .wb_op(wb_op)
    );

    // function unit latency model: done_req in cycle grant+LAT
    always @(posedge clk) begin
        for (int i = 0; i < NF; i++) begin
            if (!rst_n)           cnt[i] <= 0;
            else if (rd_grant[i]) cnt[i] <= LAT[i];
            else if (cnt[i] != 0) cnt[i] <= cnt[i] - 1;
        end
    end
    always_comb begin
        for (int i = 0; i < NF; i++) done_req[i] = (cnt[i] == 1) || force_done[i];
    end

    // event recorder
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (iss_valid && iss_ready) iss_cyc[iss_fu] <= cyc;
            for (int i = 0; i < NF; i++) begin
                if (rd_grant[i]) rd_cyc[i] <= cyc;
                if (wb_grant[i]) wb_cyc[i] <= cyc;
            end
            if (wb_grant != '0) begin
                checks++;
                if ($countones(wb_grant) != 1) begin
                    fails++;
                    $display("FAIL R6 onehot: actual %b expected one bit", wb_grant);
                end
            end
        end
    end

    task automatic check_eq(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic clear_rec();
        for (int i = 0; i < NF; i++) begin
            iss_cyc[i] = -1; rd_cyc[i] = -1; wb_cyc[i] = -1;
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // called at a negedge; returns at the negedge after acceptance
    task automatic do_issue(input int fu, input int dst, input int s1, input int s2,
                            input bit u1, input bit u2, input int op);
        iss_valid = 1'b1;
        iss_fu = 2'(fu); iss_dst = 3'(dst); iss_src1 = 3'(s1); iss_src2 = 3'(s2);
        iss_use1 = u1; iss_use2 = u2; iss_op = 4'(op);
        #1;
        while (!iss_ready) begin
            @(negedge clk); #1;
        end
        @(negedge clk);
        iss_valid = 1'b0;
    endtask

    task automatic probe_ready(input int fu, input int dst, input int exp, input string what);
        iss_fu = 2'(fu); iss_dst = 3'(dst);
        #1;
        check_eq(int'(iss_ready), exp, what);
    endtask

    task automatic t_reset();
        // R10
        probe_ready(0, 0, 1, "R10 iss_ready after reset");
        check_eq(int'(rd_grant), 0, "R10 rd_grant after reset");
        check_eq(int'(wb_grant), 0, "R10 wb_grant after reset");
    endtask

    task automatic t_basic();
        clear_rec();
        do_issue(0, 1, 2, 3, 1, 1, 5);
        probe_ready(0, 7, 0, "R1 busy unit blocks issue");
        @(negedge clk);
        @(negedge clk); #1;
        check_eq(int'(wb_grant), 1, "R6 single unit grant");
        check_eq(int'(wb_dst), 1, "R6 wb_dst");
        check_eq(int'(wb_op), 5, "R6 wb_op");
        check_eq(int'(iss_ready), 0, "R9 still busy in wb cycle");
        @(negedge clk); #1;
        check_eq(int'(iss_ready), 1, "R9 free after wb");
        settle(10);
        check_eq(rd_cyc[0] - iss_cyc[0], 1, "R3 read one cycle after issue");
        check_eq(wb_cyc[0] - iss_cyc[0], 3, "R6 wb one cycle after done");
    endtask

    task automatic t_raw();
        clear_rec();
        do_issue(2, 5, 1, 2, 1, 1, 1);
        do_issue(0, 6, 5, 1, 1, 1, 2);
        settle(20);
        check_eq(wb_cyc[2] - iss_cyc[2], 8, "R3 producer timing");
        check_eq(rd_cyc[0], wb_cyc[2] + 1, "R3 consumer woken after producer wb");
        check_eq(wb_cyc[0], wb_cyc[2] + 3, "R3 consumer wb");
    endtask

    task automatic t_same_cycle();
        clear_rec();
        do_issue(1, 2, 3, 4, 1, 1, 3);
        settle(3);
        do_issue(0, 7, 2, 2, 1, 1, 4);
        settle(10);
        check_eq(iss_cyc[0], wb_cyc[1], "R3 issue in producer wb cycle");
        check_eq(rd_cyc[0], iss_cyc[0] + 1, "R3 source counted ready at issue");
    endtask

    task automatic t_ooo();
        clear_rec();
        do_issue(3, 1, 2, 3, 1, 1, 6);
        do_issue(1, 4, 5, 6, 1, 1, 7);
        settle(20);
        check_eq(wb_cyc[3] - iss_cyc[3], 12, "R8 long op wb");
        check_eq(wb_cyc[1] - iss_cyc[1], 4, "R8 short op wb");
        check_eq(int'(wb_cyc[1] < wb_cyc[3]), 1, "R8 short op completes first");
    endtask

    task automatic t_waw();
        clear_rec();
        do_issue(2, 3, 1, 2, 1, 1, 8);
        probe_ready(0, 3, 0, "R2 reserved dst blocks issue");
        do_issue(0, 3, 4, 4, 1, 0, 9);
        settle(15);
        check_eq(wb_cyc[2] - iss_cyc[2], 8, "R2 first writer wb");
        check_eq(iss_cyc[0], wb_cyc[2] + 1, "R2 stall lifts after wb");
    endtask

    task automatic t_war();
        clear_rec();
        do_issue(3, 1, 2, 2, 1, 1, 1);
        do_issue(2, 4, 1, 5, 1, 1, 2);
        do_issue(0, 5, 6, 7, 1, 1, 3);
        settle(30);
        check_eq(wb_cyc[3] - iss_cyc[3], 12, "R7 producer wb");
        check_eq(rd_cyc[2], wb_cyc[3] + 1, "R7 reader granted");
        check_eq(wb_cyc[0], rd_cyc[2] + 1, "R7 writer held until read done");
        check_eq(wb_cyc[0] - iss_cyc[0], 12, "R7 writer delay");
    endtask

    task automatic t_ports();
        clear_rec();
        do_issue(3, 1, 0, 0, 1, 1, 1);
        do_issue(0, 2, 1, 1, 1, 1, 2);
        do_issue(1, 3, 1, 0, 1, 0, 3);
        do_issue(2, 4, 1, 0, 1, 0, 4);
        settle(30);
        check_eq(rd_cyc[0], wb_cyc[3] + 1, "R4 two-operand unit first");
        check_eq(rd_cyc[1], wb_cyc[3] + 2, "R4 one-operand unit 1 next");
        check_eq(rd_cyc[2], wb_cyc[3] + 2, "R4 one-operand unit 2 shares cycle");
    endtask

    task automatic t_wbprio();
        clear_rec();
        do_issue(1, 1, 2, 3, 1, 1, 1);
        do_issue(0, 4, 5, 6, 1, 1, 2);
        settle(12);
        check_eq(wb_cyc[0], iss_cyc[1] + 4, "R6 lower index wins");
        check_eq(wb_cyc[1], iss_cyc[1] + 5, "R6 loser next cycle");
    endtask

    task automatic t_ignore();
        clear_rec();
        force_done = 4'b1000;
        @(negedge clk);
        force_done = '0;
        #1;
        check_eq(int'(wb_grant), 0, "R5 stray done no wb");
        check_eq(int'(rd_grant), 0, "R5 stray done no read");
        probe_ready(3, 0, 1, "R5 unit still idle");
        do_issue(3, 6, 2, 3, 1, 1, 5);
        settle(20);
        check_eq(wb_cyc[3] - iss_cyc[3], 12, "R5 full latency kept");
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        clear_rec();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_raw();
        t_same_cycle();
        t_ooo();
        t_waw();
        t_war();
        t_ports();
        t_wbprio();
        t_ignore();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule